// File: doc/BRIEF.md
# PCM Serial Time-Slot Port

This block carries one companded voice sample per 8 kHz frame in each direction over a framed serial bus. On the transmit side it takes a parallel word and sends it out MSB first on a data line with a separate driver-enable. An active-low slot indicator marks the eight transmit bit times. On the receive side it shifts in eight serial bits and presents them as a parallel word with a one-cycle strobe. The block runs entirely on a fast system clock. Bit-clock and frame-sync inputs are sampled by that clock and their edges are found by comparing successive samples.

The block works out whether the bus uses short (one bit period) or long (three or more bit periods) frame syncs. It does this by counting how many bit-clock falling edges the transmit sync spans. The mode is decided when the sync pulse ends and governs the frames that follow. Each transmit sync latches a new word. The word sent in a frame is always the one latched at the previous sync, so the first frame after reset sends a fixed idle code. A select input lets the receive direction borrow the transmit bit clock.

Top module: `pcm_slot_port`

## Requirements
- R1: The mode is set only by the transmit sync. When that sync ends, the block counts the bit-clock falling edges seen while the sync was high. A count of exactly one selects short mode and a count of three or more selects long mode. The new mode applies from the next frame on. The receive sync never changes the mode.
- R2: Reset leaves the block in short mode with `dx_oe` low, `ts_n` high, `rx_valid` low and `rx_word` zero.
- R3: Short-mode transmit: the transmit sync is sampled high at a bit-clock falling edge. The next rising edge turns on `dx_oe` and presents bit 7 on `dx`. The following seven rising edges present bits 6 down to 0. The falling edge after the eighth rising edge turns `dx_oe` off.
- R4: Short-mode receive: the receive sync is sampled high at a falling edge. The next eight falling edges capture `dr`, and the first bit captured is bit 7 of `rx_word`.
- R5: Long-mode transmit: `dx_oe` turns on with bit 7 at the later of two events, the transmit sync rising or a bit-clock rising edge. The next seven rising edges present bits 6 down to 0.
- R6: Long-mode transmit: `dx_oe` turns off at the later of two events, the falling edge after the eighth rising edge or the transmit sync going low.
- R7: Long-mode receive: a rising edge of the receive sync causes `dr` to be captured on the next eight falling bit-clock edges, MSB first.
- R8: Each transmit sync rising edge latches `tx_word`. The frame started by that sync sends the word latched at the previous sync. The first frame after reset sends `IDLE_CODE`, which defaults to all ones.
- R9: `ts_n` is low from the moment the driver turns on until the falling edge after the eighth rising edge, and high at every other time.
- R10: A transmit sync spanning exactly two falling edges leaves the mode unchanged. It still starts a frame under the current mode's rules.
- R11: With `sync_sel` high the receive side is timed by `bclk_x` and `bclk_r` is ignored. With `sync_sel` low it is timed by `bclk_r`.
- R12: After the eighth receive bit is captured, `rx_word` updates and `rx_valid` pulses high for exactly one system clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bclk_x | input | 1 | Transmit bit clock |
| bclk_r | input | 1 | Receive bit clock |
| sync_sel | input | 1 | 1: receive uses the transmit bit clock |
| fs_x | input | 1 | Transmit frame sync |
| fs_r | input | 1 | Receive frame sync |
| tx_word | input | WORD_W | Word to be sent in the next frame |
| dx | output | 1 | Serial transmit data |
| dx_oe | output | 1 | Transmit driver enable |
| ts_n | output | 1 | Transmit slot indicator, active low |
| dr | input | 1 | Serial receive data |
| rx_word | output | WORD_W | Last received word |
| rx_valid | output | 1 | One-cycle strobe for a new received word |

## Verification
The sharpest coincidences occur when a frame-sync transition lands in the same system clock as a bit-clock edge. A long sync that rises together with the bit clock must latch the word, reload the shifter and turn the driver on in that one cycle. A sync that rises together with a falling edge must count that edge toward its width and still wait for the next rising edge before driving. The bench places sync transitions on both kinds of edge, and lets long syncs end both before and after the slot. In every half bit period it compares `dx_oe`, `ts_n` and `dx` with windows computed from the edge rules, so an enable or release that is off by a single edge shows up at once.

// File: rtl/pcm_slot_port.sv
module pcm_slot_port #(
  parameter int WORD_W = 8,
  parameter logic [WORD_W-1:0] IDLE_CODE = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bclk_x,
  input  logic              bclk_r,
  input  logic              sync_sel,
  input  logic              fs_x,
  input  logic              fs_r,
  input  logic [WORD_W-1:0] tx_word,
  output logic              dx,
  output logic              dx_oe,
  output logic              ts_n,
  input  logic              dr,
  output logic [WORD_W-1:0] rx_word,
  output logic              rx_valid
);
  localparam int CNT_W = $clog2(WORD_W + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_W);
  localparam logic [CNT_W-1:0] LAST_CAP = CNT_W'(WORD_W - 1);

  logic bx_q, bx_p, br_q, br_p, fx_q, fx_p, fr_q, fr_p, dr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      {bx_q, bx_p, br_q, br_p, fx_q, fx_p, fr_q, fr_p, dr_q} <= '0;
    end else begin
      bx_q <= bclk_x;  bx_p <= bx_q;
      br_q <= bclk_r;  br_p <= br_q;
      fx_q <= fs_x;    fx_p <= fx_q;
      fr_q <= fs_r;    fr_p <= fr_q;
      dr_q <= dr;
    end
  end

  wire bx_rise = bx_q & ~bx_p;
  wire bx_fall = ~bx_q & bx_p;
  wire fx_rise = fx_q & ~fx_p;
  wire fx_fall = ~fx_q & fx_p;
  wire fr_rise = fr_q & ~fr_p;
  wire rb_q    = sync_sel ? bx_q : br_q;
  wire rb_p    = sync_sel ? bx_p : br_p;
  wire rb_fall = ~rb_q & rb_p;

  // frame-width classification
  logic       long_q;
  logic [1:0] wcnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      long_q <= 1'b0;
      wcnt   <= '0;
    end else begin
      if (fx_rise)
        wcnt <= bx_fall ? 2'd1 : 2'd0;
      else if (fx_q && bx_fall && wcnt != 2'd3)
        wcnt <= wcnt + 2'd1;
      if (fx_fall) begin
        if (wcnt == 2'd1)      long_q <= 1'b0;
        else if (wcnt == 2'd3) long_q <= 1'b1;
      end
    end
  end

  // transmit
  logic [WORD_W-1:0] pend, sh;
  logic [CNT_W-1:0]  tcnt;
  logic              armed, go, oe, slot;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend  <= IDLE_CODE;
      sh    <= '0;
      tcnt  <= '0;
      armed <= 1'b0;
      go    <= 1'b0;
      oe    <= 1'b0;
      slot  <= 1'b0;
    end else if (fx_rise) begin
      pend <= tx_word;
      sh   <= pend;
      go   <= 1'b0;
      if (long_q && bx_q) begin
        oe    <= 1'b1;
        slot  <= 1'b1;
        tcnt  <= CNT_W'(1);
        armed <= 1'b0;
      end else begin
        oe    <= 1'b0;
        slot  <= 1'b0;
        tcnt  <= '0;
        armed <= 1'b1;
      end
    end else begin
      if (armed && !long_q && bx_fall && fx_q) begin
        go    <= 1'b1;
        armed <= 1'b0;
      end
      if ((go || (armed && long_q && fx_q)) && bx_rise) begin
        oe    <= 1'b1;
        slot  <= 1'b1;
        tcnt  <= CNT_W'(1);
        go    <= 1'b0;
        armed <= 1'b0;
      end else if (slot && bx_rise && tcnt != LAST_BIT) begin
        sh   <= sh << 1;
        tcnt <= tcnt + CNT_W'(1);
      end
      if (slot && bx_fall && tcnt == LAST_BIT) begin
        slot <= 1'b0;
        if (!long_q || !fx_q) oe <= 1'b0;
      end
      if (oe && !slot && !fx_q) oe <= 1'b0;
    end
  end

  assign dx    = oe ? sh[WORD_W-1] : 1'b0;
  assign dx_oe = oe;
  assign ts_n  = ~slot;

  // receive
  logic [WORD_W-1:0] rsh, rword;
  logic [CNT_W-1:0]  rcnt;
  logic              rx_armed, rx_act, rvalid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsh      <= '0;
      rword    <= '0;
      rcnt     <= '0;
      rx_armed <= 1'b0;
      rx_act   <= 1'b0;
      rvalid   <= 1'b0;
    end else begin
      rvalid <= 1'b0;
      if (fr_rise) begin
        rcnt     <= '0;
        rx_act   <= long_q;
        rx_armed <= !long_q;
      end else if (rx_armed && rb_fall && fr_q) begin
        rx_armed <= 1'b0;
        rx_act   <= 1'b1;
      end else if (rx_act && rb_fall) begin
        rsh  <= {rsh[WORD_W-2:0], dr_q};
        rcnt <= rcnt + CNT_W'(1);
        if (rcnt == LAST_CAP) begin
          rx_act <= 1'b0;
          rword  <= {rsh[WORD_W-2:0], dr_q};
          rvalid <= 1'b1;
        end
      end
    end
  end

  assign rx_word  = rword;
  assign rx_valid = rvalid;
endmodule

// File: rtl/pcm_slot_port_chk.sv
module pcm_slot_port_chk (
  input logic clk,
  input logic rst_n,
  input logic dx,
  input logic dx_oe,
  input logic ts_n,
  input logic rx_valid,
  input logic bx_rise
);
  p_slot_driven_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !ts_n |-> dx_oe);

  p_drive_on_with_slot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dx_oe) |-> $fell(ts_n));

  p_drive_off_after_slot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dx_oe) |-> ts_n);

  p_strobe_single_r12: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  p_shift_on_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (dx_oe && $past(dx_oe) && !$stable(dx)) |-> $past(bx_rise));
endmodule

bind pcm_slot_port pcm_slot_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .dx(dx), .dx_oe(dx_oe), .ts_n(ts_n),
  .rx_valid(rx_valid), .bx_rise(bx_rise)
);

// File: tb/sim_pcm_slot_port.sv
module sim_pcm_slot_port;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bclk_x = 1'b0, bclk_r = 1'b0, sync_sel = 1'b0;
  logic fs_x = 1'b0, fs_r = 1'b0, dr = 1'b0;
  logic [7:0] tx_word = '0;
  logic dx, dx_oe, ts_n, rx_valid;
  logic [7:0] rx_word;

  int nchk = 0;
  int nerr = 0;
  int vtotal = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pcm_slot_port u0 (
    .clk(clk), .rst_n(rst_n), .bclk_x(bclk_x), .bclk_r(bclk_r),
    .sync_sel(sync_sel), .fs_x(fs_x), .fs_r(fs_r), .tx_word(tx_word),
    .dx(dx), .dx_oe(dx_oe), .ts_n(ts_n), .dr(dr),
    .rx_word(rx_word), .rx_valid(rx_valid)
  );

  always @(posedge clk) if (rx_valid) vtotal <= vtotal + 1;

  task automatic chk(input logic [7:0] got, input logic [7:0] exp,
                     input string req, input string tag);
    nchk++;
    if (got !== exp) begin
      nerr++;
      $display("FAIL %s [%s] got %0h expected %0h at %0t", req, tag, got, exp, $time);
    end
  endtask

  // One frame of 14 bit periods; half h even = high half (starts at rise).
  task automatic frame(input bit lng, input int xs, input int xf,
                       input int rs, input int rf, input bit ssel,
                       input logic [7:0] tin, input logic [7:0] tout,
                       input logic [7:0] rin, input string tag);
    int e, oe_end, c0, v0;
    e      = lng ? ((xs % 2 == 0) ? xs : xs + 1) : xs + 2;
    oe_end = lng ? ((e + 15 > xf) ? e + 15 : xf) : e + 15;
    c0     = lng ? rs + 1 : rs + 3;
    v0     = vtotal;
    tx_word  = tin;
    sync_sel = ssel;
    for (int h = 0; h < 28; h++) begin
      int fh, j;
      @(negedge clk);
      bclk_x = (h % 2 == 0);
      bclk_r = ssel ? 1'b0 : (h % 2 == 0);
      fs_x   = (h >= xs && h < xf);
      fs_r   = (h >= rs && h < rf);
      fh = 2 * (h / 2) + 1;
      j  = (fh - c0) / 2;
      if (fh >= c0 && j < 8) dr = rin[7 - j];
      else dr = h[1];
      repeat (3) @(negedge clk);
      chk({7'd0, dx_oe}, {7'd0, (h >= e && h < oe_end)},
          lng ? ((h < e + 15) ? "R5" : "R6") : "R3", tag);
      chk({7'd0, ts_n}, {7'd0, !(h >= e && h <= e + 14)}, "R9", tag);
      if (h >= e && h <= e + 14)
        chk({7'd0, dx}, {7'd0, tout[7 - (h - e) / 2]}, "R8", tag);
    end
    chk(rx_word, rin, lng ? "R7 R12" : "R4 R12", tag);
    chk(8'(vtotal - v0), 8'd1, "R12", tag);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R2 reset state
    chk({7'd0, dx_oe}, 8'd0, "R2", "reset oe");
    chk({7'd0, ts_n}, 8'd1, "R2", "reset ts");
    chk({7'd0, rx_valid}, 8'd0, "R2", "reset strobe");
    chk(rx_word, 8'd0, "R2", "reset word");
    // R2 short default, R8 idle code first; R11 via sync_sel alternation
    frame(0, 2, 4, 2, 4, 0, 8'hA5, 8'hFF, 8'h3A, "R2 first short frame");
    frame(0, 2, 4, 2, 4, 1, 8'h3C, 8'hA5, 8'hC5, "R11 shared clock");
    // R1 long sync seen while short: short rules now, long afterwards
    frame(0, 2, 8, 2, 4, 0, 8'h96, 8'h3C, 8'h81, "R1 long sync in short");
    frame(1, 2, 8, 2, 8, 0, 8'h5A, 8'h96, 8'h7E, "R1 long sync with rise");
    frame(1, 3, 23, 2, 8, 1, 8'h0F, 8'h5A, 8'h01, "R6 sync at fall, held past slot");
    frame(1, 2, 6, 2, 8, 0, 8'hF0, 8'h0F, 8'h80, "R10 two-period in long");
    frame(1, 2, 4, 2, 8, 1, 8'h11, 8'hF0, 8'h55, "R1 short sync in long");
    frame(0, 2, 4, 2, 8, 0, 8'h22, 8'h11, 8'hAA, "R1 wide rx sync ignored");
    frame(0, 2, 6, 2, 4, 1, 8'h44, 8'h22, 8'h0F, "R10 two-period in short");
    frame(0, 2, 4, 2, 4, 0, 8'h00, 8'h44, 8'hF1, "R10 mode kept");
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      nerr++;
      nchk++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end
endmodule